// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts activity for a processor core. It has a free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of a vector of one-cycle event pulses, and an 8-bit code picks that line. One control word holds the whole configuration and status: the global run bit, the two clear strobes, a divide-by-64 option for the cycle counter, the three interrupt enables, the three sticky wrap flags and the two event codes.

Software uses a single register port that is addressed by a 2-bit index. A write takes one cycle, and a read is combinational from the same index. Index 0 is the control word, index 1 the cycle counter, index 2 event counter 0 and index 3 event counter 1. A write to a counter index loads that counter. The interrupt line is raised while any wrap flag is set and its enable is also set.

Top module: `perf_monitor`

## Requirements
- R1: While control bit 0 (run) is 0, no counter changes except by a register write. While it is 1, the cycle counter (with bit 3 clear) advances on every clock edge.
- R2: Writing a control word with bit 1 set zeroes both event counters on that edge and leaves the cycle counter alone. Bit 1 always reads back as 0.
- R3: Writing a control word with bit 2 set zeroes the cycle counter and its divide-by-64 stage on that edge, and leaves the event counters alone. Bit 2 always reads back as 0.
- R4: With bit 3 set, the cycle counter advances once per 64 running clock edges. The first step comes on the 64th running edge after a bit-2 clear.
- R5: Bits 4, 5 and 6 enable interrupts for event counter 0, event counter 1 and the cycle counter. The irq output is 1 exactly while some flag is set and its enable is also set.
- R6: Bits 8, 9 and 10 are wrap flags for event counter 0, event counter 1 and the cycle counter. A flag is set when its counter steps from all ones to zero.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. If a clear and a new wrap of the same counter fall on the same edge, the flag stays set.
- R8: Bits 19:12 hold the event code for counter 0 and bits 27:20 hold the code for counter 1. A counter steps when the event line with that code index pulses. Code 0xFF never counts, even if line 255 pulses.
- R9: Bits 7, 11 and 31:28 are dropped on write and always read back as 0.
- R10: A write to index 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1. A load on the same edge as an increment wins.
- R11: After reset, every counter, the control word and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register index for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the register at `addr` |
| evt_in | input | 256 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Interrupt request |

## Verification
Two cases are hard to reach from the ports: a flag clear that falls on the same edge as a fresh wrap of that counter, and a counter load that falls on the same edge as an increment. The stimulus first loads the counter with all ones. It then issues the control write (or the counter write) while the selected event line pulses in that same cycle, and reads the result back after counting has been stopped. The prescaler is checked at 63, 64 and 128 running edges after a clear, so an off-by-one step is caught on either side of the boundary.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W     = 32;
  localparam int EVT_SEL_W  = 8;
  localparam int NUM_EVT    = 1 << EVT_SEL_W;
  localparam int NCNT       = 3;

  // counter slots, ordered as the enable and flag fields
  localparam int IDX_EV0    = 0;
  localparam int IDX_EV1    = 1;
  localparam int IDX_CYC    = 2;

  // control word field positions
  localparam int B_RUN      = 0;
  localparam int B_EVCLR    = 1;
  localparam int B_CYCLR    = 2;
  localparam int B_DIV      = 3;
  localparam int B_IE_LSB   = 4;
  localparam int B_FLG_LSB  = 8;
  localparam int B_SEL0_LSB = 12;
  localparam int B_SEL1_LSB = 20;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;

  function automatic logic [1:0] slot_addr(input int idx);
    case (idx)
      IDX_EV0: slot_addr = RA_EV0;
      IDX_EV1: slot_addr = RA_EV1;
      default: slot_addr = RA_CYC;
    endcase
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [W-1:0] q_n;
  logic         q_ce;

  always_comb begin
    q_n  = q;
    q_ce = load | clr | inc;
    if (load)      q_n = load_val;
    else if (clr)  q_n = '0;
    else if (inc)  q_n = q + W'(1);
  end

  assign wrap = inc & ~load & ~clr & (&q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (q_ce)  q <= q_n;
  end
endmodule

// File: rtl/pmu_event_pick.sv
module pmu_event_pick #(
  parameter int SEL_W = 8
) (
  input  logic [(1<<SEL_W)-1:0] evt,
  input  logic [SEL_W-1:0]      sel,
  output logic                  hit
);
  // all-ones code selects nothing
  assign hit = (sel != '1) & evt[sel];
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q, div_n;
  logic                div_ce;

  always_comb begin
    div_ce = clr | run;
    div_n  = clr ? '0 : div_q + DIV_LOG2'(1);
  end

  assign tick = run & ~clr & (&div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (div_ce)  div_q <= div_n;
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_EVT-1:0]   evt_in,
  output logic                 irq
);
  logic                              glb_en, glb_en_n;
  logic                              div_on, div_on_n;
  logic [NCNT-1:0]                   int_en, int_en_n;
  logic [NCNT-1:0]                   ovf_flag, ovf_flag_n;
  logic [1:0][EVT_SEL_W-1:0]         sel_q, sel_n;
  logic                              ctrl_wr;

  logic [NCNT-1:0][CNT_W-1:0]        cnt_q;
  logic [NCNT-1:0]                   cnt_inc, cnt_clr, cnt_load, cnt_wrap;
  logic [1:0]                        evt_hit;
  logic                              div_tick;

  assign ctrl_wr = wr_en & (addr == RA_CTRL);

  // event selection per event counter
  for (genvar e = 0; e < 2; e++) begin : g_pick
    pmu_event_pick #(.SEL_W(EVT_SEL_W)) u_pick (
      .evt (evt_in),
      .sel (sel_q[e]),
      .hit (evt_hit[e])
    );
  end

  pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (glb_en),
    .clr  (cnt_clr[IDX_CYC]),
    .tick (div_tick)
  );

  always_comb begin
    cnt_inc[IDX_EV0] = glb_en & evt_hit[0];
    cnt_inc[IDX_EV1] = glb_en & evt_hit[1];
    cnt_inc[IDX_CYC] = glb_en & (div_on ? div_tick : 1'b1);
    cnt_clr[IDX_EV0] = ctrl_wr & wr_data[B_EVCLR];
    cnt_clr[IDX_EV1] = ctrl_wr & wr_data[B_EVCLR];
    cnt_clr[IDX_CYC] = ctrl_wr & wr_data[B_CYCLR];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cnt_load[i] = wr_en & (addr == slot_addr(i));
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load[i]),
      .load_val(wr_data[CNT_W-1:0]),
      .clr     (cnt_clr[i]),
      .inc     (cnt_inc[i]),
      .q       (cnt_q[i]),
      .wrap    (cnt_wrap[i])
    );
  end

  // control word next state
  always_comb begin
    glb_en_n = glb_en;
    div_on_n = div_on;
    int_en_n = int_en;
    sel_n    = sel_q;
    if (ctrl_wr) begin
      glb_en_n = wr_data[B_RUN];
      div_on_n = wr_data[B_DIV];
      int_en_n = wr_data[B_IE_LSB +: NCNT];
      sel_n[0] = wr_data[B_SEL0_LSB +: EVT_SEL_W];
      sel_n[1] = wr_data[B_SEL1_LSB +: EVT_SEL_W];
    end
    for (int i = 0; i < NCNT; i++) begin
      ovf_flag_n[i] = (ovf_flag[i] & ~(ctrl_wr & wr_data[B_FLG_LSB + i]))
                    | cnt_wrap[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      div_on <= 1'b0;
      int_en <= '0;
      sel_q  <= '0;
    end else if (ctrl_wr) begin
      glb_en <= glb_en_n;
      div_on <= div_on_n;
      int_en <= int_en_n;
      sel_q  <= sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= '0;
    else        ovf_flag <= ovf_flag_n;
  end

  // read path
  always_comb begin
    rd_data = '0;
    case (addr)
      RA_CTRL: begin
        rd_data[B_RUN]                       = glb_en;
        rd_data[B_DIV]                       = div_on;
        rd_data[B_IE_LSB +: NCNT]            = int_en;
        rd_data[B_FLG_LSB +: NCNT]           = ovf_flag;
        rd_data[B_SEL0_LSB +: EVT_SEL_W]     = sel_q[0];
        rd_data[B_SEL1_LSB +: EVT_SEL_W]     = sel_q[1];
      end
      RA_CYC:  rd_data[CNT_W-1:0] = cnt_q[IDX_CYC];
      RA_EV0:  rd_data[CNT_W-1:0] = cnt_q[IDX_EV0];
      default: rd_data[CNT_W-1:0] = cnt_q[IDX_EV1];
    endcase
  end

  assign irq = |(ovf_flag & int_en);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [1:0]                 addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       glb_en,
  input logic [EVT_SEL_W-1:0]       sel0,
  input logic [NCNT-1:0]            ovf_flag,
  input logic [NCNT-1:0]            cnt_inc,
  input logic [NCNT-1:0][CNT_W-1:0] cnt_q
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_en) |=> $stable(cnt_q)); // R1

  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CTRL && wr_data[B_EVCLR])
      |=> (cnt_q[IDX_EV0] == '0 && cnt_q[IDX_EV1] == '0)); // R2

  AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CTRL && wr_data[B_CYCLR]) |=> cnt_q[IDX_CYC] == '0); // R3

  AST_NO_EVENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == '1 && !wr_en) |=> $stable(cnt_q[IDX_EV0])); // R8

  for (genvar i = 0; i < NCNT; i++) begin : g_ck
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc[i] && cnt_q[i] == '1 && !wr_en) |=> ovf_flag[i]); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[i] && !(wr_en && addr == RA_CTRL && wr_data[B_FLG_LSB + i]))
        |=> ovf_flag[i]); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == slot_addr(i))
        |=> cnt_q[i] == $past(wr_data[CNT_W-1:0])); // R10
  end
endmodule

bind perf_monitor pmu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .glb_en  (glb_en),
  .sel0    (sel_q[0]),
  .ovf_flag(ovf_flag),
  .cnt_inc (cnt_inc),
  .cnt_q   (cnt_q)
);

// File: tb/perf_monitor_bench.sv
module perf_monitor_bench;
  import pmu_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [1:0]         addr;
  logic [DATA_W-1:0]  wr_data;
  logic [DATA_W-1:0]  rd_data;
  logic [NUM_EVT-1:0] evt_in;
  logic               irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;

  always #2 clk = ~clk;

  perf_monitor u_perf_monitor (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .evt_in (evt_in),
    .irq    (irq)
  );

  function automatic logic [NUM_EVT-1:0] ev1h(input int code);
    return NUM_EVT'(1) << code;
  endfunction

  // monitor: pops expected items and compares them to the outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rd_data;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic w, input logic [1:0] a,
                       input logic [31:0] d, input logic [NUM_EVT-1:0] ev);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; evt_in = ev;
    @(posedge clk);
    #1;
    wr_en = 1'b0; evt_in = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0);
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] ev);
    drive(1'b0, RA_CTRL, '0, ev);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    sb_item_t it;
    @(negedge clk);
    #1;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic finish_run();
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; evt_in = '0;
    idle(3);
    rst_n = 1'b1;

    // R11 reset state
    expect_reg(RA_CTRL, 32'h0, "R11 ctrl");
    expect_reg(RA_CYC,  32'h0, "R11 cyc");
    expect_reg(RA_EV0,  32'h0, "R11 ev0");
    expect_reg(RA_EV1,  32'h0, "R11 ev1");
    expect_irq(1'b0, "R11 irq");

    // R9 dropped bits
    wr(RA_CTRL, 32'hFFFF_FFF8);
    expect_reg(RA_CTRL, 32'h0FFF_F078, "R9 forced zero bits");

    // R10 loads, R1 events ignored while stopped
    wr(RA_CYC, 32'h11);
    wr(RA_EV0, 32'h22);
    wr(RA_EV1, 32'h33);
    wr(RA_CTRL, 32'h00B0_7000);
    for (int n = 0; n < 3; n++) pulse(ev1h(7) | ev1h(8'h0B));
    expect_reg(RA_CYC, 32'h11, "R10 R1 cyc load held");
    expect_reg(RA_EV0, 32'h22, "R10 R1 ev0 load held");
    expect_reg(RA_EV1, 32'h33, "R10 R1 ev1 load held");

    // R8 event counting by code
    wr(RA_CTRL, 32'h00B0_7003);
    for (int n = 0; n < 3; n++) pulse(ev1h(7));
    for (int n = 0; n < 5; n++) pulse(ev1h(8'h0B));
    for (int n = 0; n < 2; n++) pulse(ev1h(0));
    wr(RA_CTRL, 32'h00B0_7000);
    expect_reg(RA_EV0, 32'd3, "R8 ev0 code 0x07");
    expect_reg(RA_EV1, 32'd5, "R8 ev1 code 0x0B");

    // R8 code 0xFF counts nothing
    wr(RA_CTRL, 32'h0FF0_0003);
    for (int n = 0; n < 4; n++) pulse('1);
    wr(RA_CTRL, 32'h0FF0_0000);
    expect_reg(RA_EV0, 32'd4, "R8 ev0 code 0x00");
    expect_reg(RA_EV1, 32'd0, "R8 ev1 code 0xFF");

    // R2 event clear strobe
    wr(RA_EV1, 32'd9);
    wr(RA_CYC, 32'h77);
    wr(RA_CTRL, 32'h0000_0002);
    expect_reg(RA_EV0, 32'd0, "R2 ev0 cleared");
    expect_reg(RA_EV1, 32'd0, "R2 ev1 cleared");
    expect_reg(RA_CYC, 32'h77, "R2 cyc untouched");
    expect_reg(RA_CTRL, 32'h0, "R2 strobe reads 0");

    // R3 cycle clear strobe
    wr(RA_EV0, 32'd7);
    wr(RA_CTRL, 32'h0000_0004);
    expect_reg(RA_CYC, 32'd0, "R3 cyc cleared");
    expect_reg(RA_EV0, 32'd7, "R3 ev0 untouched");
    expect_reg(RA_CTRL, 32'h0, "R3 strobe reads 0");

    // R1 cycle counting every edge
    wr(RA_CTRL, 32'h0000_0005);
    idle(9);
    wr(RA_CTRL, 32'h0000_0000);
    expect_reg(RA_CYC, 32'd10, "R1 cyc counts 10 edges");

    // R4 prescale boundaries
    wr(RA_CTRL, 32'h0000_000D);
    idle(62);
    wr(RA_CTRL, 32'h0000_0008);
    expect_reg(RA_CYC, 32'd0, "R4 63 edges");
    wr(RA_CTRL, 32'h0000_000D);
    idle(63);
    wr(RA_CTRL, 32'h0000_0008);
    expect_reg(RA_CYC, 32'd1, "R4 64 edges");
    wr(RA_CTRL, 32'h0000_000D);
    idle(127);
    wr(RA_CTRL, 32'h0000_0000);
    expect_reg(RA_CYC, 32'd2, "R4 128 edges");

    // R6 wrap flags, R5 irq
    wr(RA_CYC, 32'hFFFF_FFFE);
    wr(RA_EV0, 32'hFFFF_FFFF);
    wr(RA_CTRL, 32'h0000_7011);
    pulse(ev1h(7));
    wr(RA_CTRL, 32'h0000_7010);
    expect_reg(RA_CTRL, 32'h0000_7510, "R6 ev0 and cyc flags");
    expect_reg(RA_EV0, 32'd0, "R6 ev0 wrapped");
    expect_irq(1'b1, "R5 irq from ev0");

    // R7 clear, R5 enable gating
    wr(RA_CTRL, 32'h0000_7110);
    expect_reg(RA_CTRL, 32'h0000_7410, "R7 ev0 flag cleared");
    expect_irq(1'b0, "R5 cyc flag masked");
    wr(RA_CTRL, 32'h0000_7050);
    expect_irq(1'b1, "R5 cyc flag enabled");
    wr(RA_CTRL, 32'h0000_7450);
    expect_reg(RA_CTRL, 32'h0000_7050, "R7 cyc flag cleared");
    expect_irq(1'b0, "R5 irq drops");

    // R7 collision and R10 load over increment
    wr(RA_EV1, 32'hFFFF_FFFF);
    wr(RA_CTRL, 32'h00B0_7001);
    pulse(ev1h(8'h0B));
    wr(RA_EV1, 32'hFFFF_FFFF);
    drive(1'b1, RA_CTRL, 32'h00B0_7201, ev1h(8'h0B));
    drive(1'b1, RA_EV0, 32'h0000_1234, ev1h(7));
    wr(RA_CTRL, 32'h00B0_7000);
    expect_reg(RA_CTRL, 32'h00B0_7200, "R7 wrap beats clear");
    expect_reg(RA_EV1, 32'd0, "R6 ev1 wrapped again");
    expect_reg(RA_EV0, 32'h0000_1234, "R10 load beats increment");

    done = 1'b1;
    finish_run();
  end
endmodule